// File: doc/BRIEF.md
# Hart Trap and Interrupt Controller

This block decides, once per clock, whether a 64-bit hart with machine, supervisor and user privilege takes a trap. It holds the status stack, the interrupt enable and delegation masks, and the cause and trap-value registers for machine and supervisor level. These registers sit behind a simple CSR read/write port.

The block takes three kinds of input: per-interrupt pending lines, and strobes for environment call, machine return and supervisor return. It keeps the current privilege in a register. From this it chooses between taking an interrupt, raising an exception or performing a return. When a trap is taken it picks the target level through the delegation mask, updates the interrupt-enable stack and writes the cause.

The result is reported on registered outputs: the new privilege, a one-cycle trap flag and a one-cycle illegal-instruction flag. Vector address generation, exception delegation and the interrupt sources themselves live outside.

Top module: `hart_trap_unit`

## Requirements
- R1: Only bits 1, 3, 5, 7, 9 and 11 of the enable mask (CSR 0x304) are writable: writing all ones reads back 0xAAA. The pending view at CSR 0x344 shows the pending lines ANDed with 0xAAA.
- R2: Only bits 1, 5 and 9 of the delegation mask (CSR 0x303) are writable: writing all ones reads back 0x222.
- R3: A trap that lands in machine level updates the machine status (CSR 0x300; bit 3 = MIE, bit 7 = MPIE, bits 12:11 = MPP, bit 22 = TSR). MPIE takes the old MIE, MIE clears, MPP takes the prior privilege (3 from M, 1 from S, 0 from U) and the privilege becomes 3.
- R4: A trap that lands in supervisor level updates the supervisor status (CSR 0x100; bit 1 = SIE, bit 5 = SPIE, bit 8 = SPP). SPIE takes the old SIE, SIE clears, SPP takes 1 from S or 0 from U, and the privilege becomes 1.
- R5: An environment call always traps to machine level. The cause in CSR 0x342 is 8 from U, 9 from S and 11 from M.
- R6: An interrupt writes a cause with bit 63 set and the interrupt number in the low bits, to CSR 0x342 or to CSR 0x142 for supervisor targets. Interrupts, environment calls and illegal-instruction traps write zero to the trap value at CSR 0x343 or 0x143.
- R7: An interrupt that is not delegated is taken below machine level whatever MIE holds, and in machine level only when MIE = 1. A delegated interrupt is taken in U regardless of SIE, in S only when SIE = 1, and never in M. A delegated interrupt that is held pending in M fires as soon as the hart returns to U.
- R8: Among eligible interrupts, the lowest of this rank order wins: 11, 3, 7, 9, 1, 5.
- R9: A supervisor return in S with TSR = 1 is illegal, as are a supervisor return in U and a machine return below M. An illegal return pulses the illegal flag and traps to M with cause 2. A supervisor return in M is legal even with TSR = 1.
- R10: A machine return sets MIE from MPIE, sets MPIE to 1, moves to the privilege in MPP and clears MPP to 0. A supervisor return sets SIE from SPIE, sets SPIE to 1, moves to the level in SPP and clears SPP.
- R11: An eligible interrupt takes precedence over an environment call in the same cycle; the call is not performed.
- R12: After reset the privilege is 3, both flags are low and every held register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | Registered read data, one cycle after the address |
| irq_lines | input | 12 | Interrupt pending lines, one per interrupt number |
| ecall_req | input | 1 | Environment call strobe |
| mret_req | input | 1 | Machine return strobe |
| sret_req | input | 1 | Supervisor return strobe |
| priv_lvl | output | 2 | Current privilege (0 U, 1 S, 3 M) |
| trap_taken | output | 1 | High for one cycle after a trap is taken |
| illegal_op | output | 1 | High for one cycle after an illegal return |

## Verification
The main sweep starts from every privilege level and every combination of the two global enables. At each starting point it raises each of the six implemented interrupts alone. This separates the machine-level gating from the supervisor-level gating and shows that no trap ever lands below the current level.

Several multi-bit pending patterns, each entered from U, tell the fixed rank order apart from a lowest-index or highest-index pick. Environment calls from all three levels, the held-pending-then-return sequence and the returns with and without TSR cover the status stack and the illegal cases.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] LVL_U = 2'b00;
  localparam logic [1:0] LVL_S = 2'b01;
  localparam logic [1:0] LVL_M = 2'b11;

  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_SCAUSE  = 12'h142;
  localparam logic [11:0] A_STVAL   = 12'h143;
  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_MIDELEG = 12'h303;
  localparam logic [11:0] A_MIE     = 12'h304;
  localparam logic [11:0] A_MCAUSE  = 12'h342;
  localparam logic [11:0] A_MTVAL   = 12'h343;
  localparam logic [11:0] A_MIP     = 12'h344;

  localparam int unsigned CAUSE_ILLEGAL    = 2;
  localparam int unsigned CAUSE_ECALL_BASE = 8;
  localparam int unsigned RANK_NONE        = 99;

  typedef struct packed {
    logic       tsr;
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
  } stat_t;

  // Interrupt number = 4*kind + level; kind 0 software, 1 timer, 2 external.
  // Machine level ranks ahead of supervisor; external, software, timer within a level.
  function automatic int unsigned irq_rank(input int unsigned idx);
    int unsigned lvl;
    int unsigned kind;
    int unsigned base;
    lvl  = idx % 4;
    kind = idx / 4;
    if ((lvl != 1 && lvl != 3) || kind > 2) return RANK_NONE;
    base = (lvl == 3) ? 0 : 3;
    if (kind == 2) return base;
    if (kind == 0) return base + 1;
    return base + 2;
  endfunction
endpackage

// File: rtl/trap_irq_gate.sv
module trap_irq_gate
  import trap_pkg::*;
#(
  parameter int NIRQ = 12
) (
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] en,
  input  logic [NIRQ-1:0] deleg,
  input  logic [1:0]      lvl,
  input  logic            glob_m,
  input  logic            glob_s,
  output logic [NIRQ-1:0] elig
);
  logic m_open;
  logic s_open;

  assign m_open = (lvl != LVL_M) || glob_m;
  assign s_open = (lvl == LVL_U) || ((lvl == LVL_S) && glob_s);

  for (genvar i = 0; i < NIRQ; i++) begin : g_bit
    assign elig[i] = pend[i] & en[i] & (deleg[i] ? s_open : m_open);
  end
endmodule

// File: rtl/trap_irq_pick.sv
module trap_irq_pick
  import trap_pkg::*;
#(
  parameter int NIRQ = 12,
  parameter int CW   = 4
) (
  input  logic [NIRQ-1:0] elig,
  output logic            hit,
  output logic [CW-1:0]   code
);
  int unsigned best;

  always_comb begin
    hit  = 1'b0;
    code = '0;
    best = RANK_NONE;
    for (int i = 0; i < NIRQ; i++) begin
      if (elig[i] && (irq_rank(unsigned'(i)) < best)) begin
        best = irq_rank(unsigned'(i));
        hit  = 1'b1;
        code = CW'(i);
      end
    end
  end
endmodule

// File: rtl/hart_trap_unit.sv
module hart_trap_unit
  import trap_pkg::*;
#(
  parameter int              XLEN        = 64,
  parameter int              NIRQ        = 12,
  parameter logic [NIRQ-1:0] MIE_WMASK   = 12'hAAA,
  parameter logic [NIRQ-1:0] DELEG_WMASK = 12'h222
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [NIRQ-1:0] irq_lines,
  input  logic            ecall_req,
  input  logic            mret_req,
  input  logic            sret_req,
  output logic [1:0]      priv_lvl,
  output logic            trap_taken,
  output logic            illegal_op
);
  localparam int CW = $clog2(NIRQ);

  stat_t            stat_q, stat_n;
  logic [NIRQ-1:0]  mie_q, mie_n, deleg_q, deleg_n;
  logic [XLEN-1:0]  mcause_q, mcause_n, mtval_q, mtval_n;
  logic [XLEN-1:0]  scause_q, scause_n, stval_q, stval_n;
  logic [1:0]       priv_q, priv_n;
  logic             trap_q, trap_n, ill_q, ill_n;
  logic [XLEN-1:0]  rdata_q, rd_n;

  logic [NIRQ-1:0]  elig;
  logic             irq_hit;
  logic [CW-1:0]    irq_code;

  trap_irq_gate #(.NIRQ(NIRQ)) u_gate (
    .pend(irq_lines), .en(mie_q), .deleg(deleg_q), .lvl(priv_q),
    .glob_m(stat_q.mie), .glob_s(stat_q.sie), .elig(elig)
  );

  trap_irq_pick #(.NIRQ(NIRQ), .CW(CW)) u_pick (
    .elig(elig), .hit(irq_hit), .code(irq_code)
  );

  function automatic logic [XLEN-1:0] pack_m(input stat_t s);
    logic [XLEN-1:0] v;
    v = '0;
    v[1] = s.sie;  v[3] = s.mie;  v[5] = s.spie; v[7] = s.mpie;
    v[8] = s.spp;  v[12:11] = s.mpp; v[22] = s.tsr;
    return v;
  endfunction

  function automatic logic [XLEN-1:0] pack_s(input stat_t s);
    logic [XLEN-1:0] v;
    v = '0;
    v[1] = s.sie; v[5] = s.spie; v[8] = s.spp;
    return v;
  endfunction

  logic             take, to_s, bad_ret;
  logic [XLEN-1:0]  cause;

  always_comb begin
    stat_n   = stat_q;   mie_n    = mie_q;    deleg_n = deleg_q;
    mcause_n = mcause_q; mtval_n  = mtval_q;
    scause_n = scause_q; stval_n  = stval_q;
    priv_n   = priv_q;   trap_n   = 1'b0;     ill_n   = 1'b0;
    take     = 1'b0;     to_s     = 1'b0;     cause   = '0;
    bad_ret  = (sret_req && ((priv_q == LVL_U) || ((priv_q == LVL_S) && stat_q.tsr)))
            || (mret_req && (priv_q != LVL_M));

    if (irq_hit) begin
      take  = 1'b1;
      to_s  = deleg_q[irq_code];
      cause = {1'b1, {(XLEN-1-CW){1'b0}}, irq_code};
    end else if (ecall_req) begin
      take  = 1'b1;
      cause = XLEN'(CAUSE_ECALL_BASE) + XLEN'(priv_q);
    end else if (bad_ret) begin
      take  = 1'b1;
      ill_n = 1'b1;
      cause = XLEN'(CAUSE_ILLEGAL);
    end

    if (take) begin
      trap_n = 1'b1;
      if (to_s) begin
        scause_n    = cause;
        stval_n     = '0;
        stat_n.spie = stat_q.sie;
        stat_n.sie  = 1'b0;
        stat_n.spp  = priv_q[0];
        priv_n      = LVL_S;
      end else begin
        mcause_n    = cause;
        mtval_n     = '0;
        stat_n.mpie = stat_q.mie;
        stat_n.mie  = 1'b0;
        stat_n.mpp  = priv_q;
        priv_n      = LVL_M;
      end
    end else if (mret_req) begin
      stat_n.mie  = stat_q.mpie;
      stat_n.mpie = 1'b1;
      stat_n.mpp  = LVL_U;
      priv_n      = stat_q.mpp;
    end else if (sret_req) begin
      stat_n.sie  = stat_q.spie;
      stat_n.spie = 1'b1;
      stat_n.spp  = 1'b0;
      priv_n      = {1'b0, stat_q.spp};
    end else if (csr_we) begin
      case (csr_addr)
        A_MSTATUS: begin
          stat_n.sie  = csr_wdata[1];
          stat_n.mie  = csr_wdata[3];
          stat_n.spie = csr_wdata[5];
          stat_n.mpie = csr_wdata[7];
          stat_n.spp  = csr_wdata[8];
          stat_n.mpp  = (csr_wdata[12:11] == 2'b10) ? LVL_U : csr_wdata[12:11];
          stat_n.tsr  = csr_wdata[22];
        end
        A_SSTATUS: begin
          stat_n.sie  = csr_wdata[1];
          stat_n.spie = csr_wdata[5];
          stat_n.spp  = csr_wdata[8];
        end
        A_MIE:     mie_n    = csr_wdata[NIRQ-1:0] & MIE_WMASK;
        A_MIDELEG: deleg_n  = csr_wdata[NIRQ-1:0] & DELEG_WMASK;
        A_MCAUSE:  mcause_n = csr_wdata;
        A_MTVAL:   mtval_n  = csr_wdata;
        A_SCAUSE:  scause_n = csr_wdata;
        A_STVAL:   stval_n  = csr_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (csr_addr)
      A_MSTATUS: rd_n = pack_m(stat_q);
      A_SSTATUS: rd_n = pack_s(stat_q);
      A_MIE:     rd_n = {{(XLEN-NIRQ){1'b0}}, mie_q};
      A_MIDELEG: rd_n = {{(XLEN-NIRQ){1'b0}}, deleg_q};
      A_MIP:     rd_n = {{(XLEN-NIRQ){1'b0}}, irq_lines & MIE_WMASK};
      A_MCAUSE:  rd_n = mcause_q;
      A_MTVAL:   rd_n = mtval_q;
      A_SCAUSE:  rd_n = scause_q;
      A_STVAL:   rd_n = stval_q;
      default:   rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;    mie_q   <= '0;  deleg_q <= '0;
      mcause_q <= '0;    mtval_q <= '0;
      scause_q <= '0;    stval_q <= '0;
      priv_q   <= LVL_M; trap_q  <= 1'b0; ill_q  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      stat_q   <= stat_n;   mie_q   <= mie_n;  deleg_q <= deleg_n;
      mcause_q <= mcause_n; mtval_q <= mtval_n;
      scause_q <= scause_n; stval_q <= stval_n;
      priv_q   <= priv_n;   trap_q  <= trap_n; ill_q   <= ill_n;
      rdata_q  <= rd_n;
    end
  end

  assign csr_rdata  = rdata_q;
  assign priv_lvl   = priv_q;
  assign trap_taken = trap_q;
  assign illegal_op = ill_q;
endmodule

// File: rtl/hart_trap_unit_chk.sv
module hart_trap_unit_chk
  import trap_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              NIRQ      = 12,
  parameter logic [NIRQ-1:0] MIE_WMASK = 12'hAAA
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      priv_q,
  input logic            trap_q,
  input logic            ill_q,
  input stat_t           stat_q,
  input logic [NIRQ-1:0] mie_q,
  input logic [XLEN-1:0] mcause_q,
  input logic [XLEN-1:0] mtval_q,
  input logic [XLEN-1:0] stval_q
);
  p_enable_mask_r1: assert property (@(posedge clk) disable iff (rst)
    (mie_q & ~MIE_WMASK) == '0);

  p_mtrap_stack_r3: assert property (@(posedge clk) disable iff (rst)
    (trap_q && priv_q == LVL_M) |->
      (!stat_q.mie && stat_q.mpie == $past(stat_q.mie) && stat_q.mpp == $past(priv_q)));

  p_strap_stack_r4: assert property (@(posedge clk) disable iff (rst)
    (trap_q && priv_q == LVL_S) |->
      (!stat_q.sie && stat_q.spie == $past(stat_q.sie) && stat_q.spp == $past(priv_q[0])));

  p_tval_zero_r6: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> ((priv_q == LVL_M) ? (mtval_q == '0) : (stval_q == '0)));

  p_no_fall_from_m_r7: assert property (@(posedge clk) disable iff (rst)
    (trap_q && $past(priv_q) == LVL_M) |-> (priv_q == LVL_M));

  p_illegal_cause_r9: assert property (@(posedge clk) disable iff (rst)
    ill_q |-> (trap_q && priv_q == LVL_M && mcause_q == XLEN'(CAUSE_ILLEGAL)));
endmodule

bind hart_trap_unit hart_trap_unit_chk #(
  .XLEN(XLEN), .NIRQ(NIRQ), .MIE_WMASK(MIE_WMASK)
) u_chk (
  .clk(clk), .rst(rst), .priv_q(priv_q), .trap_q(trap_q), .ill_q(ill_q),
  .stat_q(stat_q), .mie_q(mie_q), .mcause_q(mcause_q), .mtval_q(mtval_q),
  .stval_q(stval_q)
);

// File: tb/tb_hart_trap_unit.sv
module tb_hart_trap_unit;
  import trap_pkg::*;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic [11:0] irq = '0;
  logic        ecall = 1'b0, mret = 1'b0, sret = 1'b0;
  logic [1:0]  priv;
  logic        trap, ill;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [63:0] IRQ_BIT = 64'h8000_0000_0000_0000;

  hart_trap_unit dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_lines(irq),
    .ecall_req(ecall), .mret_req(mret), .sret_req(sret),
    .priv_lvl(priv), .trap_taken(trap), .illegal_op(ill)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [63:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    step();
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [63:0] v);
    csr_addr = a;
    step();
    v = csr_rdata;
  endtask

  task automatic do_ecall(); ecall = 1'b1; step(); ecall = 1'b0; endtask
  task automatic do_mret();  mret  = 1'b1; step(); mret  = 1'b0; endtask
  task automatic do_sret();  sret  = 1'b1; step(); sret  = 1'b0; endtask

  task automatic go_m();
    if (priv != LVL_M) do_ecall();
  endtask

  // Enter level p with MIE = m, SIE = s and TSR = t by a machine return.
  task automatic go_level(input logic [1:0] p, input bit m, input bit s, input bit t);
    go_m();
    csr_wr(A_MSTATUS, (64'(s) << 1) | (64'(m) << 7) | (64'(p) << 11) | (64'(t) << 22));
    do_mret();
  endtask

  function automatic bit is_deleg(input int b);
    return (b == 1) || (b == 5) || (b == 9);
  endfunction

  function automatic bit exp_take(input logic [1:0] p, input bit m, input bit s, input int b);
    if (is_deleg(b)) return (p == LVL_U) || ((p == LVL_S) && s);
    return (p != LVL_M) || m;
  endfunction

  int ord [6] = '{11, 3, 7, 9, 1, 5};
  int bits [6] = '{1, 3, 5, 7, 9, 11};
  logic [1:0] lvls [3] = '{LVL_U, LVL_S, LVL_M};
  logic [11:0] pats [8] = '{12'hAAA, 12'h222, 12'h022, 12'h020, 12'h088, 12'h0A0, 12'h280, 12'h820};

  initial begin
    logic [63:0] v;
    repeat (3) step();
    rst = 1'b0;

    // R12 reset state
    chk("R12", "priv", priv, 64'(LVL_M));
    chk("R12", "trap flag", trap, 0);
    chk("R12", "illegal flag", ill, 0);
    csr_rd(A_MSTATUS, v); chk("R12", "mstatus", v, 0);
    csr_rd(A_MCAUSE, v);  chk("R12", "mcause", v, 0);

    // R1 / R2 masks
    csr_wr(A_MIE, '1);     csr_rd(A_MIE, v);     chk("R1", "enable readback", v, 64'hAAA);
    csr_wr(A_MIDELEG, '1); csr_rd(A_MIDELEG, v); chk("R2", "deleg readback", v, 64'h222);
    irq = 12'hFFF;
    csr_rd(A_MIP, v); chk("R1", "pending view", v, 64'hAAA);
    chk("R7", "no trap in M with MIE=0", trap, 0);
    irq = '0;

    // R7 / R6 sweep: level x MIE x SIE x single interrupt
    for (int pi = 0; pi < 3; pi++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 2; s++) begin
          for (int bi = 0; bi < 6; bi++) begin
            logic [1:0] p;
            int b;
            bit t;
            p = lvls[pi];
            b = bits[bi];
            go_level(p, m[0], s[0], 1'b0);
            chk("R10", "level after return", priv, 64'(p));
            irq = 12'(1) << b;
            step();
            irq = '0;
            t = exp_take(p, m[0], s[0], b);
            chk("R7", $sformatf("taken lvl=%0d m=%0d s=%0d irq=%0d", p, m, s, b), trap, 64'(t));
            if (t) begin
              chk("R7", "target level", priv, is_deleg(b) ? 64'(LVL_S) : 64'(LVL_M));
              csr_rd(is_deleg(b) ? A_SCAUSE : A_MCAUSE, v);
              chk("R6", "interrupt cause", v, IRQ_BIT | 64'(b));
            end else begin
              chk("R7", "level unchanged", priv, 64'(p));
            end
          end
        end
      end
    end

    // R10 machine return stack
    go_level(LVL_S, 1'b1, 1'b0, 1'b0);
    csr_rd(A_MSTATUS, v); chk("R10", "mstatus after mret", v & 64'h1888, 64'h088);
    // R5 / R3 environment calls
    do_ecall();
    chk("R5", "ecall from S trap", trap, 1);
    chk("R3", "ecall from S level", priv, 64'(LVL_M));
    csr_rd(A_MCAUSE, v);  chk("R5", "ecall from S cause", v, 64'd9);
    csr_rd(A_MTVAL, v);   chk("R6", "ecall tval", v, 0);
    csr_rd(A_MSTATUS, v); chk("R3", "stack from S", v & 64'h1888, 64'h880);
    go_level(LVL_U, 1'b1, 1'b0, 1'b0);
    do_ecall();
    csr_rd(A_MCAUSE, v);  chk("R5", "ecall from U cause", v, 64'd8);
    csr_rd(A_MSTATUS, v); chk("R3", "stack from U", v & 64'h1888, 64'h080);
    go_level(LVL_M, 1'b1, 1'b0, 1'b0);
    do_ecall();
    csr_rd(A_MCAUSE, v);  chk("R5", "ecall from M cause", v, 64'd11);
    csr_rd(A_MSTATUS, v); chk("R3", "stack from M", v & 64'h1888, 64'h1880);
    go_level(LVL_M, 1'b0, 1'b0, 1'b0);
    do_ecall();
    csr_rd(A_MSTATUS, v); chk("R3", "stack from M, MIE=0", v & 64'h1888, 64'h1800);

    // R4 supervisor trap stack
    go_level(LVL_S, 1'b0, 1'b1, 1'b0);
    irq = 12'h002; step(); irq = '0;
    chk("R4", "S trap level", priv, 64'(LVL_S));
    csr_rd(A_SSTATUS, v); chk("R4", "stack from S", v & 64'h122, 64'h120);
    csr_rd(A_STVAL, v);   chk("R6", "interrupt stval", v, 0);
    go_level(LVL_U, 1'b0, 1'b1, 1'b0);
    irq = 12'h002; step(); irq = '0;
    chk("R4", "S trap from U level", priv, 64'(LVL_S));
    csr_rd(A_SSTATUS, v); chk("R4", "stack from U", v & 64'h122, 64'h020);

    // R7 delegated interrupt held in M fires on drop to U
    go_m();
    csr_wr(A_MSTATUS, (64'd1 << 3) | (64'd1 << 7));
    irq = 12'h002;
    step();
    chk("R7", "held in M", trap, 0);
    do_mret();
    chk("R7", "return to U", priv, 64'(LVL_U));
    step();
    chk("R7", "fires in U", trap, 1);
    chk("R7", "fires to S", priv, 64'(LVL_S));
    irq = '0;
    csr_rd(A_SCAUSE, v); chk("R7", "fired cause", v, IRQ_BIT | 64'd1);

    // R8 priority
    for (int k = 0; k < 8; k++) begin
      int e;
      e = -1;
      for (int j = 5; j >= 0; j--) if (pats[k][ord[j]]) e = ord[j];
      go_level(LVL_U, 1'b0, 1'b0, 1'b0);
      irq = pats[k];
      step();
      irq = '0;
      chk("R8", $sformatf("trap for %0h", pats[k]), trap, 1);
      chk("R8", "winner level", priv, is_deleg(e) ? 64'(LVL_S) : 64'(LVL_M));
      csr_rd(is_deleg(e) ? A_SCAUSE : A_MCAUSE, v);
      chk("R8", $sformatf("winner for %0h", pats[k]), v, IRQ_BIT | 64'(e));
    end

    // R11 interrupt over ecall
    go_level(LVL_U, 1'b0, 1'b0, 1'b0);
    irq = 12'h080; ecall = 1'b1;
    step();
    irq = '0; ecall = 1'b0;
    csr_rd(A_MCAUSE, v); chk("R11", "interrupt wins", v, IRQ_BIT | 64'd7);
    csr_rd(A_MSTATUS, v); chk("R11", "stack from U only", v & 64'h1800, 64'h0);

    // R9 TSR and illegal returns
    go_level(LVL_S, 1'b0, 1'b0, 1'b1);
    do_sret();
    chk("R9", "illegal flag on sret TSR", ill, 1);
    chk("R9", "level after illegal", priv, 64'(LVL_M));
    csr_rd(A_MCAUSE, v);  chk("R9", "illegal cause", v, 64'd2);
    csr_rd(A_MSTATUS, v); chk("R9", "illegal from S", v & 64'h1800, 64'h0800);
    go_level(LVL_S, 1'b0, 1'b0, 1'b0);
    csr_wr(A_SSTATUS, 64'h20);
    do_sret();
    chk("R10", "sret legal flag", ill, 0);
    chk("R10", "sret to U", priv, 64'(LVL_U));
    csr_rd(A_SSTATUS, v); chk("R10", "sret stack", v & 64'h122, 64'h022);
    do_mret();
    chk("R9", "mret in U illegal", ill, 1);
    chk("R9", "mret in U level", priv, 64'(LVL_M));
    csr_wr(A_MSTATUS, (64'd1 << 22) | (64'd1 << 8) | (64'd1 << 5));
    do_sret();
    chk("R9", "sret in M with TSR legal", ill, 0);
    chk("R10", "sret from M to S", priv, 64'(LVL_S));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule